// File: doc/BRIEF.md
# Disk Boot Retry Sequencer

The block drives a cold start from disk. On a start request it posts a progress code to a front-panel style display, lays down a small command block in shared memory through a single-word memory port, and kicks the disk controller by storing the block's address into a fixed control word. It then polls the status word of the block until the controller marks it as written, or until a two-level poll budget runs out.

A written status with a clean low byte ends the boot: the block raises `done_o` and offers the fixed start address on `start_pc_o` for the execution engine to pick up. A written status with a non-zero low byte is a failed read; the whole attempt (progress code, block setup, kick, poll) is repeated. Two distinct failure codes separate "the controller never answered" from "it answered, but every attempt went wrong". The poll budget and retry limit are parameters so a short simulation can exercise every exit.

Top module: `disk_boot_seq`

## Requirements
- R1: `start_i` begins a boot only when the block is idle, done or failed; a `start_i` pulse while an attempt is in progress has no effect on the number of attempts or poll reads.
- R2: Every attempt begins with a one-cycle `panel_stb_o` pulse carrying `panel_code_o` = 120 (decimal), before any memory write of that attempt.
- R3: Each attempt writes, in this order: zero to the control words at octal 520..523; the command block at octal 1000..1005 with the values 0, 0, 44000 (octal), 2000 (octal), 402 (octal), 1; and finally 1000 (octal) to the control word at octal 521, which starts the controller.
- R4: After the start write, the block issues only reads, all to the status word at octal 1001; a status counts as written when bits [11:8] (bit 0 = LSB) equal 4'hF, and bits above 11 are ignored.
- R5: A written status whose bits [7:0] are zero ends the boot: `done_o` rises, `start_pc_o` reads 1, and no further memory access is made until the next start.
- R6: A written status with non-zero bits [7:0] starts a new attempt (R2, R3) unless the retry limit is reached.
- R7: When `RETRY_N` attempts in a row end with a non-zero low byte, `fail_o` rises and `panel_code_o` is 122 with a `panel_stb_o` pulse.
- R8: Each attempt makes at most `INNER_N`×`OUTER_N` status reads; if none of them is written, `fail_o` rises with `panel_code_o` = 121; a status seen on the last allowed read is still accepted.
- R9: After reset the block is idle: `done_o`, `fail_o`, `panel_stb_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a boot |
| mem_req_o | output | 1 | Memory access request this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid the cycle after a read request |
| panel_stb_o | output | 1 | One-cycle pulse when a new panel code is posted |
| panel_code_o | output | 8 | Last posted panel code (120, 121 or 122) |
| done_o | output | 1 | Boot succeeded, held until next start |
| fail_o | output | 1 | Boot failed, held until next start |
| start_pc_o | output | AW | Start address handed to execution |

## Verification
A corrupted write step counter shows at once as a wrong address or value in the command block or as the start write arriving before the block is complete, which the memory model catches at the start write itself. A poll counter off by one changes the number of status reads before a timeout by one, visible when the status arrives exactly on the last allowed read versus one read later. A wrong retry count shows as one attempt too many or too few, counted from the panel strobes and the start writes, and a wrongly decoded marker or low byte turns a success into a timeout or retry within one poll.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_WR, ST_RD, ST_EV, ST_DONE, ST_FAIL
  } dbs_state_e;

  localparam logic [15:0] ADDR_CTRL = 16'o520;   // four control words
  localparam logic [15:0] ADDR_BLK  = 16'o1000;  // command block base
  localparam logic [15:0] ADDR_STAT = 16'o1001;  // status word in block
  localparam logic [15:0] CMD_RD3   = 16'o44000;
  localparam logic [15:0] PTR_HDR   = 16'o2000;
  localparam logic [15:0] PTR_LBL   = 16'o402;
  localparam logic [15:0] PTR_DATA  = 16'o1;
  localparam logic [3:0]  STAT_MARK = 4'hF;

  localparam int unsigned N_CLR = 4;
  localparam int unsigned N_BLK = 6;
  localparam int unsigned N_WR  = N_CLR + N_BLK + 1;

  localparam logic [7:0] CODE_BOOT   = 8'd120;
  localparam logic [7:0] CODE_NOSTAT = 8'd121;
  localparam logic [7:0] CODE_BADBT  = 8'd122;
endpackage

// File: rtl/dbs_cmd_rom.sv
module dbs_cmd_rom import dbs_pkg::*; #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 4
) (
  input  logic [SW-1:0] step_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  int unsigned s;
  logic [15:0] a, d;

  always_comb begin
    s = 32'(step_i);
    a = '0;
    d = '0;
    if (s < N_CLR) begin
      a = ADDR_CTRL + 16'(s);
    end else if (s < N_CLR + N_BLK) begin
      a = ADDR_BLK + 16'(s - N_CLR);
      case (s - N_CLR)
        2:       d = CMD_RD3;
        3:       d = PTR_HDR;
        4:       d = PTR_LBL;
        5:       d = PTR_DATA;
        default: d = '0;
      endcase
    end else begin
      // kick: block pointer into second control word
      a = ADDR_CTRL + 16'd1;
      d = ADDR_BLK;
    end
    addr_o = AW'(a);
    data_o = DW'(d);
  end
endmodule

// File: rtl/dbs_poll_timer.sv
module dbs_poll_timer #(
  parameter int unsigned INNER_N = 16384,
  parameter int unsigned OUTER_N = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic last_o
);
  localparam int unsigned IW = (INNER_N > 1) ? $clog2(INNER_N) : 1;
  localparam int unsigned OW = (OUTER_N > 1) ? $clog2(OUTER_N) : 1;

  logic [IW-1:0] inner_q;
  logic [OW-1:0] outer_q;
  logic inner_last, outer_last;

  assign inner_last = (inner_q == IW'(INNER_N - 1));
  assign outer_last = (outer_q == OW'(OUTER_N - 1));
  assign last_o     = inner_last && outer_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inner_q <= '0;
      outer_q <= '0;
    end else if (clr_i) begin
      inner_q <= '0;
      outer_q <= '0;
    end else if (step_i) begin
      if (inner_last) begin
        inner_q <= '0;
        if (!outer_last) outer_q <= outer_q + 1'b1;
      end else begin
        inner_q <= inner_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbs_attempt_ctr.sv
module dbs_attempt_ctr #(
  parameter int unsigned RETRY_N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = (RETRY_N > 1) ? $clog2(RETRY_N) : 1;

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(RETRY_N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !last_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/disk_boot_seq.sv
module disk_boot_seq import dbs_pkg::*; #(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 16,
  parameter int unsigned INNER_N = 16384,
  parameter int unsigned OUTER_N = 16,
  parameter int unsigned RETRY_N = 8,
  parameter int unsigned BOOT_PC = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          panel_stb_o,
  output logic [7:0]    panel_code_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] start_pc_o
);
  localparam int unsigned SW = $clog2(N_WR);

  dbs_state_e    state_q;
  logic [SW-1:0] step_q;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_data;
  logic          stb_q;
  logic [7:0]    code_q;
  logic          stored, clean, can_start;
  logic          tim_clr, tim_step, tim_last;
  logic          att_clr, att_inc, att_last;
  logic          unused_rdata;

  assign stored       = (mem_rdata_i[11:8] == STAT_MARK);
  assign clean        = (mem_rdata_i[7:0] == 8'h00);
  assign unused_rdata = ^mem_rdata_i[DW-1:12];
  assign can_start    = start_i &&
                        (state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_FAIL);

  dbs_cmd_rom #(.AW(AW), .DW(DW), .SW(SW)) u_rom (
    .step_i (step_q),
    .addr_o (rom_addr),
    .data_o (rom_data)
  );

  assign tim_clr  = (state_q == ST_PROG);
  assign tim_step = (state_q == ST_EV) && !stored;

  dbs_poll_timer #(.INNER_N(INNER_N), .OUTER_N(OUTER_N)) u_tim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tim_clr),
    .step_i (tim_step),
    .last_o (tim_last)
  );

  assign att_clr = can_start;
  assign att_inc = (state_q == ST_EV) && stored && !clean;

  dbs_attempt_ctr #(.RETRY_N(RETRY_N)) u_att (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (att_clr),
    .inc_i  (att_inc),
    .last_o (att_last)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    if (state_q == ST_WR) begin
      mem_req_o   = 1'b1;
      mem_we_o    = 1'b1;
      mem_addr_o  = rom_addr;
      mem_wdata_o = rom_data;
    end else if (state_q == ST_RD) begin
      mem_req_o   = 1'b1;
      mem_addr_o  = AW'(ADDR_STAT);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      stb_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      stb_q <= 1'b0;
      if (can_start) begin
        state_q <= ST_PROG;
        stb_q   <= 1'b1;
        code_q  <= CODE_BOOT;
      end else begin
        case (state_q)
          ST_PROG: begin
            state_q <= ST_WR;
            step_q  <= '0;
          end
          ST_WR: begin
            if (step_q == SW'(N_WR - 1)) state_q <= ST_RD;
            else                         step_q  <= step_q + 1'b1;
          end
          ST_RD: state_q <= ST_EV;
          ST_EV: begin
            if (stored) begin
              if (clean) begin
                state_q <= ST_DONE;
              end else begin
                state_q <= att_last ? ST_FAIL : ST_PROG;
                stb_q   <= 1'b1;
                code_q  <= att_last ? CODE_BADBT : CODE_BOOT;
              end
            end else if (tim_last) begin
              state_q <= ST_FAIL;
              stb_q   <= 1'b1;
              code_q  <= CODE_NOSTAT;
            end else begin
              state_q <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign panel_stb_o  = stb_q;
  assign panel_code_o = code_q;
  assign done_o       = (state_q == ST_DONE);
  assign fail_o       = (state_q == ST_FAIL);
  assign start_pc_o   = AW'(BOOT_PC);
endmodule

// File: rtl/dbs_chk.sv
module dbs_chk import dbs_pkg::*; #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic [DW-1:0] mem_rdata_i,
  input logic          panel_stb_o,
  input logic [7:0]    panel_code_o,
  input logic          done_o,
  input logic          fail_o
);
  AST_READ_STATUS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_addr_o == AW'(ADDR_STAT))) else $error("read addr"); // R4

  AST_POLL_AFTER_KICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_addr_o == AW'(ADDR_CTRL + 16'd1) && mem_wdata_o == DW'(ADDR_BLK))
    |=> (mem_req_o && !mem_we_o)) else $error("no poll after kick"); // R3

  AST_CLEAN_STATUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mem_req_o && !mem_we_o) && mem_rdata_i[11:0] == 12'hF00) |=> done_o)
    else $error("clean status not done"); // R5

  AST_NO_ACCESS_WHEN_ENDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o) |-> !mem_req_o) else $error("access after end"); // R5

  AST_END_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o)) else $error("done and fail"); // R5

  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o) else $error("done dropped"); // R5

  AST_FAIL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> (panel_stb_o && (panel_code_o == CODE_NOSTAT || panel_code_o == CODE_BADBT)))
    else $error("fail code"); // R7

  AST_PROG_BEFORE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (panel_stb_o && panel_code_o == CODE_BOOT) |-> !mem_req_o) else $error("prog overlap"); // R2
endmodule

bind disk_boot_seq dbs_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_rdata_i  (mem_rdata_i),
  .panel_stb_o  (panel_stb_o),
  .panel_code_o (panel_code_o),
  .done_o       (done_o),
  .fail_o       (fail_o)
);

// File: tb/disk_boot_seq_tb.sv
`timescale 1ns/1ps
module disk_boot_seq_tb;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 16;
  localparam int unsigned IN_N = 4;
  localparam int unsigned OUT_N = 3;
  localparam int unsigned RT_N = 3;
  localparam int MAX_RD = IN_N * OUT_N;

  typedef struct packed {
    logic [15:0] s0;
    logic [15:0] s1;
    logic [15:0] s2;
    logic [7:0]  dly;   // reads per attempt returning empty status
    logic [1:0]  kind;  // 0 done, 1 no-status, 2 bad boot
    logic [3:0]  atts;
    logic [7:0]  reads;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h0F00, 16'h0F00, 16'h0F00, 8'd0,   2'd0, 4'd1, 8'd1},
    '{16'h0F05, 16'h0F00, 16'h0F00, 8'd0,   2'd0, 4'd2, 8'd2},
    '{16'h0F80, 16'h0F80, 16'h0F80, 8'd0,   2'd2, 4'd3, 8'd3},
    '{16'h0F00, 16'h0F00, 16'h0F00, 8'd255, 2'd1, 4'd1, 8'd12},
    '{16'h0E00, 16'h0E00, 16'h0E00, 8'd0,   2'd1, 4'd1, 8'd12},
    '{16'h0F01, 16'h0F10, 16'h0F00, 8'd2,   2'd0, 4'd3, 8'd9},
    '{16'h0F00, 16'h0F00, 16'h0F00, 8'd11,  2'd0, 4'd1, 8'd12},
    '{16'h0F00, 16'h0F00, 16'h0F00, 8'd12,  2'd1, 4'd1, 8'd12},
    '{16'hAF00, 16'hAF00, 16'hAF00, 8'd1,   2'd0, 4'd1, 8'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] rdata_q;
  logic panel_stb, done, fail;
  logic [7:0] panel_code;
  logic [AW-1:0] start_pc;

  always #2 clk = ~clk;

  disk_boot_seq #(.AW(AW), .DW(DW), .INNER_N(IN_N), .OUTER_N(OUT_N), .RETRY_N(RT_N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(rdata_q),
    .panel_stb_o(panel_stb), .panel_code_o(panel_code),
    .done_o(done), .fail_o(fail), .start_pc_o(start_pc)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // memory / controller model state
  logic [15:0] mem [1024];
  logic wipe = 1'b0;
  logic [15:0] cur_s [3];
  int cur_dly = 0;
  int att_idx, reads_att, total_reads, prog_cnt, late_req, order_bad, bad_addr;

  always @(posedge clk) begin
    if (wipe) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 16'hDEAD;
      att_idx <= -1; reads_att <= 0; total_reads <= 0; prog_cnt <= 0;
      late_req <= 0; order_bad <= 0; bad_addr <= 0;
      rdata_q <= '0;
    end else begin
      if (panel_stb && panel_code == 8'd120) prog_cnt <= prog_cnt + 1;
      if ((done || fail) && mem_req) late_req <= late_req + 1;
      if (mem_req && mem_addr >= 16'd1024) bad_addr <= bad_addr + 1;
      if (mem_req && mem_we && mem_addr < 16'd1024) begin
        mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_addr == 16'o521 && mem_wdata == 16'o1000) begin
          att_idx <= att_idx + 1;
          reads_att <= 0;
          if (mem[10'o1002] != 16'o44000 || mem[10'o1003] != 16'o2000 ||
              mem[10'o1004] != 16'o402 || mem[10'o1005] != 16'o1 ||
              mem[10'o1000] != 16'o0 || mem[10'o1001] != 16'o0 ||
              mem[10'o520] != 16'o0 || mem[10'o522] != 16'o0 || mem[10'o523] != 16'o0)
            order_bad <= order_bad + 1;
        end
      end
      if (mem_req && !mem_we && mem_addr < 16'd1024) begin
        total_reads <= total_reads + 1;
        reads_att <= reads_att + 1;
        if (mem_addr == 16'o1001 && att_idx >= 0 && reads_att >= cur_dly)
          rdata_q <= cur_s[(att_idx > 2) ? 2 : att_idx];
        else
          rdata_q <= mem[mem_addr[9:0]];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_wipe();
    @(negedge clk); wipe = 1'b1;
    @(negedge clk); wipe = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || fail) && n < 3000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    cur_s[0] = v.s0; cur_s[1] = v.s1; cur_s[2] = v.s2; cur_dly = int'(v.dly);
    do_wipe();
    pulse_start();
    wait_end();
    repeat (5) @(negedge clk);
    if (v.kind == 2'd0) begin
      chk(done && !fail, $sformatf("R5 vec%0d done", idx), int'(done), 1);
      chk(start_pc == 16'd1, $sformatf("R5 vec%0d start_pc", idx), int'(start_pc), 1);
    end else if (v.kind == 2'd1) begin
      chk(fail && !done && panel_code == 8'd121, $sformatf("R8 vec%0d code", idx), int'(panel_code), 121);
    end else begin
      chk(fail && !done && panel_code == 8'd122, $sformatf("R7 vec%0d code", idx), int'(panel_code), 122);
    end
    chk(prog_cnt == int'(v.atts), $sformatf("R2 vec%0d progress pulses", idx), prog_cnt, int'(v.atts));
    chk(att_idx + 1 == int'(v.atts), $sformatf("R6 vec%0d attempts", idx), att_idx + 1, int'(v.atts));
    chk(total_reads == int'(v.reads), $sformatf("R4 vec%0d reads", idx), total_reads, int'(v.reads));
    chk(order_bad == 0 && bad_addr == 0, $sformatf("R3 vec%0d block before kick", idx), order_bad, 0);
    chk(mem[10'o1002] == 16'o44000 && mem[10'o1003] == 16'o2000 && mem[10'o1004] == 16'o402
        && mem[10'o1005] == 16'o1 && mem[10'o1000] == 16'o0 && mem[10'o1001] == 16'o0,
        $sformatf("R3 vec%0d block words", idx), int'(mem[10'o1002]), 'o44000);
    chk(mem[10'o521] == 16'o1000 && mem[10'o520] == 16'o0 && mem[10'o522] == 16'o0
        && mem[10'o523] == 16'o0, $sformatf("R3 vec%0d control words", idx), int'(mem[10'o521]), 'o1000);
    chk(late_req == 0, $sformatf("R5 vec%0d no access after end", idx), late_req, 0);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cur_s[0] = 16'h0; cur_s[1] = 16'h0; cur_s[2] = 16'h0;
    wipe = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!done && !fail && !panel_stb && !mem_req, "R9 reset outputs", int'(done | fail | panel_stb | mem_req), 0);
    rst_n = 1'b1;
    wipe = 1'b0;
    repeat (2) @(negedge clk);
    chk(!done && !fail && !mem_req, "R9 idle after reset", int'(mem_req), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R1: extra start while polling is ignored
    cur_s[0] = 16'h0; cur_s[1] = 16'h0; cur_s[2] = 16'h0; cur_dly = 255;
    do_wipe();
    pulse_start();
    repeat (18) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end();
    repeat (3) @(negedge clk);
    chk(prog_cnt == 1, "R1 busy start ignored, progress", prog_cnt, 1);
    chk(total_reads == MAX_RD, "R1 busy start ignored, reads", total_reads, MAX_RD);
    chk(fail && panel_code == 8'd121, "R1 busy start ignored, code", int'(panel_code), 121);

    // R9 reset during polling
    do_wipe();
    pulse_start();
    repeat (16) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!done && !fail && !mem_req && !panel_stb, "R9 reset mid-run", int'(mem_req), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mem_req && !done, "R9 stays idle after reset", int'(mem_req), 0);

    // recovery after reset: normal boot
    run_vec(VECS[0], 100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule